// File: doc/BRIEF.md
# Banked GPIO Port Controller

This block is a memory-mapped general-purpose I/O port for a parameterised number of pins, split into register sets of 32 pins. Pin n lives in set n/32 at bit n mod 32. Software on a simple 32-bit register bus (byte address, write enable, write data, combinational read data) chooses per pin whether it drives or listens. It also sets output levels, either with a whole-word write or atomically through write-one-to-set and write-one-to-clear aliases. It reads the pad levels back through a multi-flop synchronizer.

The register sets sit at a fixed 40-byte pitch starting at byte 0x10, so set bases are 0x10, 0x38, 0x60, 0x88, 0xB0. Each set reserves ten words, and only the first five belong to this block. The remaining words of each set, and every address outside the sets, read as zero and ignore writes.

Top module: `gpio_bank_port`

## Requirements
- R1: Set s starts at byte address 0x10 + 0x28*s. Inside a set, +0x0 is the direction word, +0x4 the output data word, +0x8 the set alias, +0xC the clear alias and +0x10 the input word. Address bits [1:0] are ignored. Pin n maps to set n/32, bit n mod 32.
- R2: While rst_n is low and after its release, every direction bit is 1 and every output data bit is 0, so pad_oe and pad_out are all zero.
- R3: A direction bit of 1 makes its pin an input and a 0 makes it an output. pad_oe is the inverse of the direction register and changes on the clock edge that takes the write.
- R4: A write to the output data word replaces all 32 output bits of that set. pad_out shows the new value after that edge.
- R5: A write to the set alias sets the output bits where the write data is 1 and leaves the others unchanged.
- R6: A write to the clear alias clears the output bits where the write data is 1 and leaves the others unchanged.
- R7: The input word returns pad_in as sampled two clock edges earlier. This holds whatever the pin's direction. Writes to the input word have no effect.
- R8: Reads of the set alias and the clear alias return the current output data word of that set.
- R9: Reads of unmapped addresses return 0, and writes to them change no register. Unmapped addresses are offsets +0x14 to +0x24 of a set, bytes below 0x10, and everything above the last set.
- R10: A write to one set leaves the direction and output registers of every other set unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pad_in | input | NUM_PINS | Pad levels, asynchronous |
| pad_out | output | NUM_PINS | Output levels to pads |
| pad_oe | output | NUM_PINS | Output enables to pads |

## Verification
The assertions check on every cycle, for the first set, that the output enables follow a direction write and that set and clear aliases touch only masked bits. They also check that the input word lags the pads by exactly two edges, that alias reads mirror the pad outputs, and that low unmapped addresses read zero. Only the bench scenarios show the full address map across both sets, the independence of the sets, and that writes to input and interrupt words are ignored. The scenarios also cover the ignored address low bits and long random mixes of whole-word, set and clear writes checked against a reference model.

// File: rtl/gpiobank_pkg.sv
package gpiobank_pkg;
   localparam int PINS_PER_SET   = 32;
   localparam int WORDS_PER_SET  = 10;
   localparam int FIRST_SET_BYTE = 16;
   localparam int LIVE_WORDS     = 5;

   typedef enum logic [2:0] {
      W_DIR  = 3'd0,
      W_OUT  = 3'd1,
      W_SET  = 3'd2,
      W_CLR  = 3'd3,
      W_IN   = 3'd4,
      W_NONE = 3'd7
   } word_e;

   function automatic int set_base_byte(input int s);
      return FIRST_SET_BYTE + s * WORDS_PER_SET * 4;
   endfunction
endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
   import gpiobank_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int NSETS  = 2,
   localparam int SEL_W = (NSETS > 1) ? $clog2(NSETS) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [SEL_W-1:0]  set_idx,
   output word_e             word
);
   always_comb begin
      int widx;
      int bw;
      widx    = int'(addr) >>> 2;
      hit     = 1'b0;
      set_idx = '0;
      word    = W_NONE;
      for (int s = 0; s < NSETS; s++) begin
         bw = set_base_byte(s) / 4;
         if (widx >= bw && widx < bw + LIVE_WORDS) begin
            hit     = 1'b1;
            set_idx = SEL_W'(s);
            word    = word_e'(3'(widx - bw));
         end
      end
   end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpiobank_pkg::*;
#(
   parameter int SET_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  word_e            word,
   input  logic [SET_W-1:0] wdata,
   output logic [SET_W-1:0] dir_q,
   output logic [SET_W-1:0] out_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q <= '1;
         out_q <= '0;
      end else if (sel) begin
         case (word)
            W_DIR:   dir_q <= wdata;
            W_OUT:   out_q <= wdata;
            W_SET:   out_q <= out_q | wdata;
            W_CLR:   out_q <= out_q & ~wdata;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
   parameter int WIDTH  = 64,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stage [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_bank_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) stage[i] <= '0;
            else if (i == 0) stage[i] <= d;
            else stage[i] <= stage[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_bank_port.sv
module gpio_bank_port
   import gpiobank_pkg::*;
#(
   parameter int NUM_PINS    = 64,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_we,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe
);
   localparam int NSETS = NUM_PINS / PINS_PER_SET;
   localparam int SEL_W = (NSETS > 1) ? $clog2(NSETS) : 1;
   localparam int TOP_BYTE = set_base_byte(NSETS-1) + LIVE_WORDS * 4;

   generate
      if (NUM_PINS % PINS_PER_SET != 0 || NSETS < 1 || NSETS > 5) begin : g_bad_pins
         $error("gpio_bank_port: NUM_PINS must be 32, 64, 96, 128 or 160");
      end
      if (TOP_BYTE > (1 << ADDR_W)) begin : g_bad_addr
         $error("gpio_bank_port: ADDR_W too narrow for the register sets");
      end
   endgenerate

   logic             dec_hit;
   logic [SEL_W-1:0] dec_set;
   word_e            dec_word;

   gpio_bank_decode #(.ADDR_W(ADDR_W), .NSETS(NSETS)) u_dec (
      .addr    (bus_addr),
      .hit     (dec_hit),
      .set_idx (dec_set),
      .word    (dec_word)
   );

   logic [NUM_PINS-1:0] in_sync;

   gpio_bank_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (in_sync)
   );

   logic [31:0] dir_w [NSETS];
   logic [31:0] out_w [NSETS];
   logic [31:0] in_w  [NSETS];

   generate
      for (genvar s = 0; s < NSETS; s++) begin : g_set
         logic sel_s;
         assign sel_s = bus_we && dec_hit && (dec_set == SEL_W'(s));

         gpio_bank_regs #(.SET_W(PINS_PER_SET)) u_regs (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (sel_s),
            .word  (dec_word),
            .wdata (bus_wdata),
            .dir_q (dir_w[s]),
            .out_q (out_w[s])
         );

         assign in_w[s] = in_sync[s*PINS_PER_SET +: PINS_PER_SET];
         assign pad_out[s*PINS_PER_SET +: PINS_PER_SET] = out_w[s];
         assign pad_oe [s*PINS_PER_SET +: PINS_PER_SET] = ~dir_w[s];
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (dec_hit) begin
         case (dec_word)
            W_DIR:               bus_rdata = dir_w[dec_set];
            W_OUT, W_SET, W_CLR: bus_rdata = out_w[dec_set];
            W_IN:                bus_rdata = in_w[dec_set];
            default:             bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/gpio_bank_port_chk.sv
module gpio_bank_port_chk #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic [31:0]       pad_in,
   input logic [31:0]       pad_out,
   input logic [31:0]       pad_oe
);
   localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(16);
   localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(24);
   localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(28);
   localparam logic [ADDR_W-1:0] A_IN  = ADDR_W'(32);

   logic [1:0] cyc;
   always_ff @(posedge clk) begin
      if (!rst_n) cyc <= '0;
      else if (cyc != 2'd3) cyc <= cyc + 2'd1;
   end

   a_r3_oe_follows_dir: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd1 && $past(bus_we && bus_addr == A_DIR)) |-> pad_oe == ~$past(bus_wdata));

   a_r5_set_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd1 && $past(bus_we && bus_addr == A_SET)) |-> pad_out == ($past(pad_out) | $past(bus_wdata)));

   a_r6_clear_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd1 && $past(bus_we && bus_addr == A_CLR)) |-> pad_out == ($past(pad_out) & ~$past(bus_wdata)));

   a_r7_input_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd2 && bus_addr == A_IN) |-> bus_rdata == $past(pad_in, 2));

   a_r8_alias_reads: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A_SET || bus_addr == A_CLR) |-> bus_rdata == pad_out);

   a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr < A_DIR) |-> bus_rdata == 32'd0);
endmodule

bind gpio_bank_port gpio_bank_port_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pad_in    (pad_in[31:0]),
   .pad_out   (pad_out[31:0]),
   .pad_oe    (pad_oe[31:0])
);

// File: tb/gpio_bank_port_bench.sv
module gpio_bank_port_bench;
   localparam int NUM_PINS = 64;
   localparam int ADDR_W   = 8;
   localparam int NSETS    = NUM_PINS / 32;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [ADDR_W-1:0]   bus_addr = '0;
   logic                bus_we = 1'b0;
   logic [31:0]         bus_wdata = '0;
   logic [31:0]         bus_rdata;
   logic [NUM_PINS-1:0] pad_in = '0;
   logic [NUM_PINS-1:0] pad_out;
   logic [NUM_PINS-1:0] pad_oe;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   gpio_bank_port #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_gpio_bank_port (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe)
   );

   // reference model built from the requirements
   logic [31:0]         m_dir [NSETS];
   logic [31:0]         m_out [NSETS];
   logic [NUM_PINS-1:0] m_q1, m_q2;

   always @(posedge clk) begin
      if (!rst_n) begin m_q1 <= '0; m_q2 <= '0; end
      else begin m_q1 <= pad_in; m_q2 <= m_q1; end
   end

   // returns set index and word offset (0..4) or -1 when unmapped (R1, R9)
   function automatic int map_set(input int a);
      for (int s = 0; s < NSETS; s++)
         if ((a >> 2) >= (16 + 40*s)/4 && (a >> 2) < (16 + 40*s)/4 + 5) return s;
      return -1;
   endfunction

   function automatic int map_word(input int a, input int s);
      return (a >> 2) - (16 + 40*s)/4;
   endfunction

   function automatic logic [31:0] exp_read(input int a);
      int s;
      s = map_set(a);
      if (s < 0) return 32'd0;
      case (map_word(a, s))
         0:       return m_dir[s];
         1, 2, 3: return m_out[s];
         4:       return m_q2[s*32 +: 32];
         default: return 32'd0;
      endcase
   endfunction

   function automatic void model_write(input int a, input logic [31:0] d);
      int s;
      s = map_set(a);
      if (s < 0) return;
      case (map_word(a, s))
         0: m_dir[s] = d;
         1: m_out[s] = d;
         2: m_out[s] = m_out[s] | d;
         3: m_out[s] = m_out[s] & ~d;
         default: ;
      endcase
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = ADDR_W'(a); bus_we = 1'b1; bus_wdata = d;
      @(posedge clk);
      model_write(a, d);
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input string req, input int a);
      @(negedge clk);
      bus_we = 1'b0; bus_addr = ADDR_W'(a);
      #1;
      check(req, 64'(bus_rdata), 64'(exp_read(a)));
   endtask

   task automatic check_pads(input string req);
      logic [NUM_PINS-1:0] eo, ee;
      for (int s = 0; s < NSETS; s++) begin
         eo[s*32 +: 32] = m_out[s];
         ee[s*32 +: 32] = ~m_dir[s];
      end
      check({req, " pad_out"}, 64'(pad_out), 64'(eo));
      check({req, " pad_oe"},  64'(pad_oe),  64'(ee));
   endtask

   initial begin
      for (int i = 0; i < 20000; i++) @(posedge clk);
      if (!done) begin
         fails++; tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int dummy;
      dummy = $urandom(32'h5eed_1234);
      for (int s = 0; s < NSETS; s++) begin m_dir[s] = '1; m_out[s] = '0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R2: reset state
      check("R2 reset pad_oe", 64'(pad_oe), 64'd0);
      check("R2 reset pad_out", 64'(pad_out), 64'd0);
      rst_n = 1'b1;
      rd("R2 reset dir set0", 16'h10);
      rd("R2 reset dir set1", 16'h38);

      // R3 direction and output enable
      wr(16'h10, 32'h0000_FFFF);
      check_pads("R3 dir write");
      check("R3 oe low half", 64'(pad_oe[31:0]), 64'hFFFF_0000);

      // R4, R5, R6 directed
      wr(16'h14, 32'hF0F0_0000);
      check("R4 whole word", 64'(pad_out[31:0]), 64'hF0F0_0000);
      wr(16'h18, 32'h0000_00FF);
      check("R5 set alias", 64'(pad_out[31:0]), 64'hF0F0_00FF);
      wr(16'h1C, 32'hF000_000F);
      check("R6 clear alias", 64'(pad_out[31:0]), 64'h00F0_00F0);
      rd("R8 set alias read", 16'h18);
      rd("R8 clear alias read", 16'h1C);
      check("R8 alias value", 64'(bus_rdata), 64'h00F0_00F0);

      // R1 low address bits ignored, set1 base
      rd("R1 low bits ignored", 16'h13);
      check("R1 low bits value", 64'(bus_rdata), 64'h0000_FFFF);
      wr(16'h3C, 32'hA5A5_5A5A);
      check("R1 set1 output bits", 64'(pad_out[63:32]), 64'hA5A5_5A5A);

      // R10 independence
      check("R10 set0 untouched", 64'(pad_out[31:0]), 64'h00F0_00F0);
      wr(16'h38, 32'h0);
      check_pads("R10 set1 dir only");

      // R7 two-edge latency, also on output pins
      @(negedge clk);
      pad_in = {32'h1357_9BDF, 32'hCAFE_F00D};
      bus_addr = ADDR_W'(16'h20);
      @(posedge clk); @(negedge clk);
      check("R7 after one edge", 64'(bus_rdata), 64'h0);
      @(posedge clk); @(negedge clk);
      check("R7 after two edges", 64'(bus_rdata), 64'hCAFE_F00D);
      rd("R7 set1 input", 16'h48);
      wr(16'h20, 32'h0);
      rd("R7 write ignored", 16'h20);
      check("R7 write ignored value", 64'(bus_rdata), 64'hCAFE_F00D);

      // R9 unmapped
      wr(16'h24, 32'hFFFF_FFFF);
      wr(16'h00, 32'hFFFF_FFFF);
      wr(16'hF0, 32'hFFFF_FFFF);
      check_pads("R9 unmapped writes");
      rd("R9 interrupt word", 16'h24);
      rd("R9 below first set", 16'h04);
      rd("R9 above last set", 16'hC0);

      // random mix
      for (int i = 0; i < 400; i++) begin
         int a;
         logic [31:0] d;
         a = int'($urandom_range(0, 255));
         d = $urandom();
         if ($urandom_range(0, 3) == 0) begin
            @(negedge clk);
            pad_in = {$urandom(), $urandom()};
         end
         if ($urandom_range(0, 1) == 0) begin
            wr(a, d);
            check_pads("R4 R5 R6 R10 random write");
         end else begin
            rd("R1 R8 R9 random read", a);
         end
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule